// File: doc/BRIEF.md
# PWM Time-Base Counter with Phase Synchronization

This block is the timing heart of one pulse-width modulator channel. A 16-bit counter advances on a prescaled clock enable and counts up, down, or up then down between zero and a programmable period. The period written on the input port is held as a shadow value and becomes active only when the counter steps through zero, so a period change takes effect at a cycle boundary.

Channels are locked together through a sync chain. When phase loading is enabled, a sync pulse forces the counter to a programmable phase value on the next counting step, so each channel keeps a fixed lead or lag against its neighbours. The sync output feeds the next channel and can pass the incoming sync, mark the zero event, or stay quiet. Single-clock zero and period event pulses drive the downstream compare and action logic.

Top module: `pwm_timebase`

## Requirements
- R1: While rst_ni is low and in the first clock after its release, cnt_o is 0, dir_o is 1 and zero_o, prd_o and sync_o are 0.
- R2: With mode_i = 0 (up), each counting step sets cnt_o to cnt_o + 1, or to 0 when cnt_o is at or above the active period; dir_o is 1.
- R3: With mode_i = 1 (down), each counting step sets cnt_o to cnt_o - 1, or to the active period when cnt_o is 0; dir_o is 0.
- R4: With mode_i = 2 (up-down), counting up reverses to down once cnt_o is at or above the active period, counting down reverses to up at 0; dir_o shows the direction of the last step (1 up, 0 down); with a period of 0 the counter stays at 0.
- R5: presc_i = n makes a counting step on the clock edges k (counted from 0 at the first edge after reset) where k mod 2^n equals 2^n - 1.
- R6: period_i is copied to the active period on a counting step taken while cnt_o is 0, and that copied value already governs the step; at other times a change of period_i has no effect on the count.
- R7: zero_o (cnt_o equals 0) and prd_o (cnt_o equals the active period) are high for exactly the one clock that follows the counting step producing that value.
- R8: With phase_en_i high, a sync_i pulse loads phase_i into cnt_o on the next counting step (the same edge if that edge is one), leaving dir_o unchanged.
- R9: With phase_en_i low, sync_i has no effect on the count, and a pending sync is dropped.
- R10: sync_sel_i = 1 makes sync_o equal sync_i delayed by one clock; sync_sel_i = 2 makes sync_o equal zero_o; sync_sel_i = 0 or 3 holds sync_o at 0.
- R11: With mode_i = 3 (hold), the counter, direction and active period are frozen and zero_o and prd_o stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | 0 up, 1 down, 2 up-down, 3 hold |
| presc_i | input | 2 | Counting step every 2^presc_i clocks |
| period_i | input | 16 | Shadow period value |
| phase_i | input | 16 | Value loaded on sync |
| phase_en_i | input | 1 | Enables phase loading from sync_i |
| sync_i | input | 1 | Sync pulse from the previous channel |
| sync_sel_i | input | 2 | Sync output source: 0 off, 1 pass, 2 zero event, 3 off |
| cnt_o | output | 16 | Counter value |
| dir_o | output | 1 | Direction of the last step, 1 up |
| zero_o | output | 1 | Counter-equals-zero pulse |
| prd_o | output | 1 | Counter-equals-period pulse |
| sync_o | output | 1 | Sync pulse to the next channel |

## Verification
The step properties assume the mode stays fixed across the edge they look at and that phase loading is off, since a phase load may put the counter anywhere. The bench resets before every configuration and keeps mode, prescaler and output select constant within a run, while it toggles phase_en_i in windows so that both the loaded and the ignored sync cases occur. Period changes are applied mid-run at arbitrary counter values to probe the shadow behaviour.

// File: rtl/pwm_timebase_pkg.sv
package pwm_timebase_pkg;
  typedef enum logic [1:0] {
    MODE_UP     = 2'd0,
    MODE_DOWN   = 2'd1,
    MODE_UPDOWN = 2'd2,
    MODE_HOLD   = 2'd3
  } cnt_mode_e;

  typedef enum logic [1:0] {
    SO_OFF  = 2'd0,
    SO_PASS = 2'd1,
    SO_ZERO = 2'd2,
    SO_NONE = 2'd3
  } sync_sel_e;
endpackage

// File: rtl/pwm_tb_prescaler.sv
module pwm_tb_prescaler #(
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] presc_i,
  output logic             tick_o
);
  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W:0]   mask_w;

  always_comb begin
    mask_w = ((DIV_W+1)'(1) << presc_i) - (DIV_W+1)'(1);
    tick_o = (div_q & mask_w[DIV_W-1:0]) == mask_w[DIV_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + DIV_W'(1);
  end
endmodule

// File: rtl/pwm_tb_sync_in.sv
module pwm_tb_sync_in (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic adv_i,
  input  logic phase_en_i,
  input  logic sync_i,
  output logic ld_o
);
  logic pend_q, pend_d;

  always_comb begin
    ld_o   = adv_i && phase_en_i && (pend_q || sync_i);
    pend_d = pend_q;
    if (!phase_en_i) pend_d = 1'b0;
    else if (ld_o)   pend_d = 1'b0;
    else if (sync_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end
endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter
  import pwm_timebase_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cnt_mode_e        mode_i,
  input  logic             adv_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] phase_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o,
  output logic             zero_o,
  output logic             prd_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, per_q, per_n;
  logic             dir_q, dir_d, zero_q, prd_q;

  always_comb begin
    // shadow copy happens on the step out of zero
    per_n = (adv_i && cnt_q == '0) ? period_i : per_q;
    cnt_d = cnt_q;
    dir_d = dir_q;
    if (ld_i) begin
      cnt_d = phase_i;
    end else if (adv_i) begin
      unique case (mode_i)
        MODE_UP: begin
          cnt_d = (cnt_q >= per_n) ? '0 : cnt_q + ONE;
          dir_d = 1'b1;
        end
        MODE_DOWN: begin
          cnt_d = (cnt_q == '0) ? per_n : cnt_q - ONE;
          dir_d = 1'b0;
        end
        MODE_UPDOWN: begin
          if (dir_q) begin
            if (cnt_q >= per_n) begin
              dir_d = 1'b0;
              cnt_d = (cnt_q == '0) ? '0 : cnt_q - ONE;
            end else begin
              cnt_d = cnt_q + ONE;
            end
          end else begin
            if (cnt_q == '0) begin
              dir_d = 1'b1;
              cnt_d = (per_n == '0) ? '0 : ONE;
            end else begin
              cnt_d = cnt_q - ONE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      dir_q  <= 1'b1;
      per_q  <= '0;
      zero_q <= 1'b0;
      prd_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      dir_q  <= dir_d;
      per_q  <= per_n;
      zero_q <= adv_i && (cnt_d == '0);
      prd_q  <= adv_i && (cnt_d == per_n);
    end
  end

  assign cnt_o  = cnt_q;
  assign dir_o  = dir_q;
  assign zero_o = zero_q;
  assign prd_o  = prd_q;
endmodule

// File: rtl/pwm_tb_sync_out.sv
module pwm_tb_sync_out
  import pwm_timebase_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  sync_sel_e sel_i,
  input  logic      sync_i,
  input  logic      zero_evt_i,
  output logic      sync_o
);
  logic src;

  always_comb begin
    unique case (sel_i)
      SO_PASS: src = sync_i;
      SO_ZERO: src = zero_evt_i;
      default: src = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_o <= 1'b0;
    else         sync_o <= src;
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_timebase_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRESC_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [1:0]         mode_i,
  input  logic [PRESC_W-1:0] presc_i,
  input  logic [CNT_W-1:0]   period_i,
  input  logic [CNT_W-1:0]   phase_i,
  input  logic               phase_en_i,
  input  logic               sync_i,
  input  logic [1:0]         sync_sel_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               dir_o,
  output logic               zero_o,
  output logic               prd_o,
  output logic               sync_o
);
  cnt_mode_e mode;
  sync_sel_e sel;
  logic      tick, adv, ld;
  logic      zero_evt;

  assign mode = cnt_mode_e'(mode_i);
  assign sel  = sync_sel_e'(sync_sel_i);
  assign adv  = tick && (mode != MODE_HOLD);

  pwm_tb_prescaler #(.SEL_W(PRESC_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .presc_i(presc_i),
    .tick_o (tick)
  );

  pwm_tb_sync_in u_sync_in (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (adv),
    .phase_en_i(phase_en_i),
    .sync_i    (sync_i),
    .ld_o      (ld)
  );

  pwm_tb_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode),
    .adv_i   (adv),
    .ld_i    (ld),
    .period_i(period_i),
    .phase_i (phase_i),
    .cnt_o   (cnt_o),
    .dir_o   (dir_o),
    .zero_o  (zero_o),
    .prd_o   (prd_o)
  );

  // zero event aligned with zero_o, one register later
  pwm_tb_sync_out u_sync_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel),
    .sync_i    (sync_i),
    .zero_evt_i(adv && (u_cnt.cnt_d == '0)),
    .sync_o    (zero_evt)
  );

  assign sync_o = zero_evt;
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
  parameter int CNT_W = 16,
  parameter int PRESC_W = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [1:0]         mode_i,
  input logic               phase_en_i,
  input logic               sync_i,
  input logic [1:0]         sync_sel_i,
  input logic [CNT_W-1:0]   cnt_o,
  input logic               dir_o,
  input logic               zero_o,
  input logic               prd_o,
  input logic               sync_o
);
  // R7
  zero_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_o |-> cnt_o == '0);

  // R2
  up_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 && !phase_en_i) |=>
      (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + CNT_W'(1) || cnt_o == '0) && dir_o);

  // R3
  down_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd1 && !phase_en_i) |=>
      !dir_o && (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) - CNT_W'(1) || $past(cnt_o) == '0));

  // R11
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'd3 |=> $stable(cnt_o) && $stable(dir_o) && !zero_o && !prd_o);

  // R10
  sync_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_sel_i == 2'd0 || sync_sel_i == 2'd3) |=> !sync_o);

  // R10
  sync_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_sel_i == 2'd1 |=> sync_o == $past(sync_i));
endmodule

bind pwm_timebase pwm_timebase_chk #(.CNT_W(CNT_W), .PRESC_W(PRESC_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_i    (mode_i),
  .phase_en_i(phase_en_i),
  .sync_i    (sync_i),
  .sync_sel_i(sync_sel_i),
  .cnt_o     (cnt_o),
  .dir_o     (dir_o),
  .zero_o    (zero_o),
  .prd_o     (prd_o),
  .sync_o    (sync_o)
);

// File: tb/pwm_timebase_bench.sv
`timescale 1ns/1ps
module pwm_timebase_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_i = '0, presc_i = '0, sync_sel_i = '0;
  logic [15:0] period_i = '0, phase_i = '0;
  logic        phase_en_i = 1'b0, sync_i = 1'b0;
  logic [15:0] cnt_o;
  logic        dir_o, zero_o, prd_o, sync_o;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench-side expectation state
  int e_cnt, e_dir, e_per, e_k, e_zero, e_prd, e_sync;
  bit e_pend;

  always #10 clk = ~clk;

  pwm_timebase u_pwm_timebase (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i), .presc_i(presc_i),
    .period_i(period_i), .phase_i(phase_i), .phase_en_i(phase_en_i),
    .sync_i(sync_i), .sync_sel_i(sync_sel_i), .cnt_o(cnt_o), .dir_o(dir_o),
    .zero_o(zero_o), .prd_o(prd_o), .sync_o(sync_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    @(negedge clk);
    // R1: outputs during reset
    chk("R1", "cnt in reset", int'(cnt_o), 0);
    chk("R1", "dir in reset", int'(dir_o), 1);
    chk("R1", "events in reset", int'({zero_o, prd_o, sync_o}), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    e_cnt = 0; e_dir = 1; e_per = 0; e_k = 0; e_pend = 0;
    e_zero = 0; e_prd = 0; e_sync = 0;
  endtask

  // one clock edge of expected behaviour derived from R2..R11
  task automatic step_expect();
    int mask, tick, ld, pn, nc, nd, m;
    m    = int'(mode_i);
    mask = (1 << presc_i) - 1;
    tick = ((e_k & mask) == mask) && (m != 3);   // R5, R11
    e_k++;
    ld   = tick && phase_en_i && (e_pend || sync_i);   // R8, R9
    if (!phase_en_i) e_pend = 0;
    else if (ld) e_pend = 0;
    else if (sync_i) e_pend = 1;
    pn = (tick && e_cnt == 0) ? int'(period_i) : e_per;   // R6
    nc = e_cnt; nd = e_dir;
    if (ld) nc = int'(phase_i);
    else if (tick) begin
      case (m)
        0: begin nc = (e_cnt >= pn) ? 0 : e_cnt + 1; nd = 1; end
        1: begin nc = (e_cnt == 0) ? pn : e_cnt - 1; nd = 0; end
        2: begin
          if (e_dir == 1) begin
            if (e_cnt >= pn) begin nd = 0; nc = (e_cnt == 0) ? 0 : e_cnt - 1; end
            else nc = e_cnt + 1;
          end else begin
            if (e_cnt == 0) begin nd = 1; nc = (pn == 0) ? 0 : 1; end
            else nc = e_cnt - 1;
          end
        end
        default: ;
      endcase
    end
    e_zero = tick && (nc == 0);   // R7
    e_prd  = tick && (nc == pn);
    e_sync = (sync_sel_i == 2'd1) ? int'(sync_i) : (sync_sel_i == 2'd2) ? e_zero : 0;  // R10
    e_cnt = nc; e_dir = nd; e_per = pn;
  endtask

  function automatic string mode_req(input int m);
    case (m)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R11";
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int pers[4] = '{0, 1, 3, 6};
    // sweep: mode x prescaler x period x sync select
    for (int m = 0; m < 4; m++)
      for (int ps = 0; ps < 4; ps++)
        for (int pi = 0; pi < 4; pi++)
          for (int ss = 0; ss < 4; ss++) begin
            mode_i = 2'(m); presc_i = 2'(ps); sync_sel_i = 2'(ss);
            period_i = 16'(pers[pi]); phase_i = 16'(2 + pi);
            sync_i = 0; phase_en_i = 0;
            do_reset();
            for (int c = 0; c < 60; c++) begin
              sync_i     = (c % 17) == 9;         // R8 / R9 stimulus
              phase_en_i = (c % 34) < 20;
              if (c == 25) period_i = 16'(pers[(pi + 2) % 4]);   // R6 mid-run change
              @(posedge clk);
              step_expect();
              @(negedge clk);
              chk(mode_req(m), "cnt", int'(cnt_o), e_cnt);
              chk((m == 2) ? "R4" : mode_req(m), "dir", int'(dir_o), e_dir);
              chk("R7", "zero", int'(zero_o), e_zero);
              chk("R7", "prd", int'(prd_o), e_prd);
              chk("R10", "sync_o", int'(sync_o), e_sync);
            end
          end

    // R5 directed: divide by 8, up, long period; 80 edges give 10 steps
    mode_i = 0; presc_i = 3; period_i = 100; sync_sel_i = 0; phase_en_i = 0; sync_i = 0;
    do_reset();
    repeat (80) @(posedge clk);
    @(negedge clk);
    chk("R5", "cnt after 80 clocks /8", int'(cnt_o), 10);

    // R1 directed: first clock after release, prescaler /2 so no step yet
    presc_i = 1;
    do_reset();
    chk("R1", "cnt after release", int'(cnt_o), 0);
    chk("R1", "dir after release", int'(dir_o), 1);

    // R6 directed: active period 4, shorten shadow at count 2; wraps at 4 first
    mode_i = 0; presc_i = 0; period_i = 4;
    do_reset();
    repeat (2) @(posedge clk);
    @(negedge clk);
    period_i = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R6", "wrap uses old period", int'(cnt_o), 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R6", "new period active", int'(cnt_o), 0);

    // R9 directed: sync ignored with phase loading off
    mode_i = 0; period_i = 50; phase_i = 40; phase_en_i = 0;
    do_reset();
    repeat (5) @(posedge clk);
    @(negedge clk);
    sync_i = 1;
    @(negedge clk);
    sync_i = 0;
    @(negedge clk);
    chk("R9", "sync ignored", int'(cnt_o), 7);

    // R8 directed: sync with phase loading on loads phase at the next step
    phase_en_i = 1; sync_i = 1;
    @(negedge clk);
    sync_i = 0;
    chk("R8", "phase loaded", int'(cnt_o), 40);
    @(negedge clk);
    chk("R8", "counts on from phase", int'(cnt_o), 41);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule